// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog for a system controller. A down-counter is loaded from a programmable period and steps once per coarse tick, which a prescaler derives from the block clock. When the count runs out, the block drives a reset request for a fixed number of cycles and then waits, stopped, until software services it again. Every control action is guarded by a 16-bit key. Feeding, re-enabling and clearing the expiry status each need one key written to their own register. Disabling needs two keys written back to back. Stray writes from runaway code therefore rarely change the timer.

One tick before expiry, the block sets a warning event that can raise a maskable interrupt, so software gets a last chance to log state. Software can read the live count, with a flag marking the cycle in which the count is about to change. A sticky status word records that an expiry happened, and only power-on reset or its clear key removes it. A debug input can freeze the countdown while a debugger holds the system. A register bit lets the timer keep running anyway.

The controller has five states. OFF is disabled. ARMED is re-enabled and waiting for a feed. RUN is counting down. BITE drives the reset pulse. HALT has expired and is stopped. The transitions are: rearm (OFF to ARMED), start (ARMED to RUN on a feed), expire (RUN to BITE when the count is zero), release (BITE to HALT after the pulse), revive (HALT to RUN on a feed), and kill (any state to OFF on a completed disable sequence). Registers sit at 4-byte spacing and are addressed by a 6-bit byte address. Reads return data in the same cycle that bus_rd is high, and writes take effect at the next clock edge.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the timer is OFF. Reads return: LOCKB (0x14) = 0xDABE, FLAG (0x18) = 0x0000, LEVEL (0x0C) = 0x0000, PERIOD (0x08) = 0x7FFF, EVT (0x20) = 0. The irq and rst_req outputs are low.
- R2: Writing 0xFEED to KICK (0x00) in ARMED, RUN or HALT loads the count from PERIOD and restarts the prescaler. Any other value, or any write in OFF, changes nothing.
- R3: PERIOD (0x08) keeps only bits 14:0 of a write (tick units), so writing 0xFFFF reads back 0x7FFF.
- R4: Writing 0xACED to REARM (0x04) in OFF moves to ARMED, where LOCKB reads 0x0000. No countdown happens until a feed. Other values are ignored.
- R5: Writing 0x2BAD to LOCKA (0x10), then 0xCAFE to LOCKB (0x14) as the very next write, moves to OFF. A wrong key, or any other write in between, cancels the sequence.
- R6: In RUN the count drops by one every TICK_DIV cycles. The first drop comes TICK_DIV cycles after the feed edge.
- R7: When the count is zero in RUN, rst_req goes high for exactly RST_CYC cycles starting on the next edge. The count then stays at zero (HALT) until a feed.
- R8: Expiry latches FLAG = 0xCFE8. Only a write of 0xE8B4 to FLAG, or power-on reset, returns it to 0x0000.
- R9: LEVEL bit 15 is high in exactly the cycles in which the next edge will step the count. Bits 14:0 give the count.
- R10: EVT (0x20) bit 0 is set when the count steps from 2 to 1. Writing 1 to it clears it. irq is high only when EVT bit 0 and MSK (0x24) bit 0 are both set.
- R11: While FRC (0x28) bit 0 is 1, EVT bit 0 is set.
- R12: DBG (0x1C) bit 1 reads the dbg_attached input. While dbg_attached is high and DBG bit 0 is 0, the countdown freezes. With bit 0 set, it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not reading |
| dbg_attached | input | 1 | Debugger holds the system |
| irq | output | 1 | Warning interrupt |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench builds the block with TICK_DIV = 4, RST_CYC = 3 and the full 15-bit count. With these values a short period expires within a few dozen cycles, so the warning, the reset pulse and HALT can be timed to the exact cycle. A four-cycle tick also lets a run of consecutive reads of LEVEL catch each busy cycle and each step. Larger periods are used to keep the timer alive while the disable sequence, the force bit and the debug freeze are exercised.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    typedef enum logic [2:0] {
        ST_OFF, ST_ARMED, ST_RUN, ST_BITE, ST_HALT
    } wdk_state_e;

    // word indices (byte address / 4)
    localparam int RG_KICK   = 0;
    localparam int RG_REARM  = 1;
    localparam int RG_PERIOD = 2;
    localparam int RG_LEVEL  = 3;
    localparam int RG_LOCKA  = 4;
    localparam int RG_LOCKB  = 5;
    localparam int RG_FLAG   = 6;
    localparam int RG_DBG    = 7;
    localparam int RG_EVT    = 8;
    localparam int RG_MSK    = 9;
    localparam int RG_FRC    = 10;

    localparam logic [15:0] KEY_FEED  = 16'hFEED;
    localparam logic [15:0] KEY_REARM = 16'hACED;
    localparam logic [15:0] KEY_LOCKA = 16'h2BAD;
    localparam logic [15:0] KEY_LOCKB = 16'hCAFE;
    localparam logic [15:0] KEY_CLR   = 16'hE8B4;
    localparam logic [15:0] VAL_OFF   = 16'hDABE;
    localparam logic [15:0] VAL_FIRED = 16'hCFE8;
endpackage

// File: rtl/wdk_prescale.sv
module wdk_prescale #(
    parameter int DIV = 328
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    assign tick = en && (phase == P_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          phase <= '0;
        else if (clr || tick) phase <= '0;
        else if (en)         phase <= phase + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R6
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr || tick) |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/wdk_core.sv
module wdk_core
    import wdk_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int RST_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic             feed_req,
    input  logic             rearm_req,
    input  logic             kill_req,
    output wdk_state_e       st,
    output logic [CNT_W-1:0] cnt,
    output logic             reload,
    output logic             warn,
    output logic             bite,
    output logic             run
);
    localparam int BW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [BW-1:0] B_LAST = BW'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);

    wdk_state_e st_n;
    logic [BW-1:0] bcnt;

    always_comb begin
        st_n = st;
        unique case (st)
            ST_OFF:   if (rearm_req) st_n = ST_ARMED;
            ST_ARMED: if (feed_req) st_n = ST_RUN;
            ST_RUN:   if (!feed_req && cnt == '0) st_n = ST_BITE;
            ST_BITE:  if (bcnt == B_LAST) st_n = ST_HALT;
            ST_HALT:  if (feed_req) st_n = ST_RUN;
            default:  st_n = ST_OFF;
        endcase
        if (kill_req) st_n = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_n;
    end

    always_comb begin
        run    = (st == ST_RUN);
        bite   = (st == ST_BITE);
        reload = feed_req && !kill_req &&
                 (st == ST_ARMED || st == ST_RUN || st == ST_HALT);
        warn   = run && tick && !reload && (cnt == C_TWO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bcnt <= '0;
        end else begin
            if (reload)                      cnt <= period;
            else if (run && tick && cnt != '0) cnt <= cnt - 1'b1;
            if (!bite)                       bcnt <= '0;
            else if (bcnt != B_LAST)         bcnt <= bcnt + 1'b1;
        end
    end

    // R2
    reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> cnt == $past(period));
    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !reload && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));
    // R7
    bite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bite && bcnt != B_LAST && !kill_req) |=> bite);
    // R7
    halt_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && !feed_req) |=> $stable(cnt));
    // R5
    kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_req |=> st == ST_OFF);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdk_pkg::*;
#(
    parameter int TICK_DIV = 328,
    parameter int CNT_W    = 15,
    parameter int RST_CYC  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        dbg_attached,
    output logic        irq,
    output logic        rst_req
);
    logic [3:0]  idx;
    logic        aligned;
    logic [15:0] wsel;

    assign idx     = bus_addr[5:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wsel    = (bus_wr && aligned) ? (16'd1 << idx) : 16'd0;

    logic [CNT_W-1:0] period_q;
    logic msk_q, frc_q, evt_q, flag_q, dbg_run_q, seq_q;

    wdk_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic reload, warn, bite, run, tick;
    logic feed_req, rearm_req, kill_req, flag_clr, pre_en;

    assign feed_req  = wsel[RG_KICK]  && bus_wdata == KEY_FEED;
    assign rearm_req = wsel[RG_REARM] && bus_wdata == KEY_REARM;
    assign kill_req  = wsel[RG_LOCKB] && bus_wdata == KEY_LOCKB && seq_q;
    assign flag_clr  = wsel[RG_FLAG]  && bus_wdata == KEY_CLR;
    assign pre_en    = run && !(dbg_attached && !dbg_run_q);

    wdk_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(pre_en), .clr(reload), .tick(tick)
    );

    wdk_core #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(period_q),
        .feed_req(feed_req), .rearm_req(rearm_req), .kill_req(kill_req),
        .st(st), .cnt(cnt), .reload(reload), .warn(warn), .bite(bite), .run(run)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q  <= '1;
            msk_q     <= 1'b0;
            frc_q     <= 1'b0;
            evt_q     <= 1'b0;
            flag_q    <= 1'b0;
            dbg_run_q <= 1'b0;
            seq_q     <= 1'b0;
        end else begin
            if (wsel[RG_PERIOD]) period_q  <= bus_wdata[CNT_W-1:0];
            if (wsel[RG_MSK])    msk_q     <= bus_wdata[0];
            if (wsel[RG_FRC])    frc_q     <= bus_wdata[0];
            if (wsel[RG_DBG])    dbg_run_q <= bus_wdata[0];
            if (bus_wr)          seq_q     <= wsel[RG_LOCKA] && bus_wdata == KEY_LOCKA;
            if (warn || frc_q)                      evt_q <= 1'b1;
            else if (wsel[RG_EVT] && bus_wdata[0]) evt_q <= 1'b0;
            if (bite)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign irq     = evt_q && msk_q;
    assign rst_req = bite;

    always_comb begin
        bus_rdata = 16'd0;
        if (bus_rd && aligned) begin
            case (idx)
                4'(RG_PERIOD): bus_rdata = 16'(period_q);
                4'(RG_LEVEL): begin
                    bus_rdata     = 16'(cnt);
                    bus_rdata[15] = tick;
                end
                4'(RG_LOCKB): bus_rdata = (st == ST_OFF) ? VAL_OFF : 16'd0;
                4'(RG_FLAG):  bus_rdata = flag_q ? VAL_FIRED : 16'd0;
                4'(RG_DBG):   bus_rdata = {14'd0, dbg_attached, dbg_run_q};
                4'(RG_EVT):   bus_rdata = {15'd0, evt_q};
                4'(RG_MSK):   bus_rdata = {15'd0, msk_q};
                4'(RG_FRC):   bus_rdata = {15'd0, frc_q};
                default:      bus_rdata = 16'd0;
            endcase
        end
    end

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    // R10
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn |=> evt_q);
    // R12
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_attached && !dbg_run_q) |-> !tick);
    // R7
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> flag_q);
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
    localparam int TDIV = 4;
    localparam int RCYC = 3;

    localparam logic [5:0] A_KICK = 6'h00, A_REARM = 6'h04, A_PERIOD = 6'h08,
                           A_LEVEL = 6'h0C, A_LOCKA = 6'h10, A_LOCKB = 6'h14,
                           A_FLAG = 6'h18, A_DBG = 6'h1C, A_EVT = 6'h20,
                           A_MSK = 6'h24, A_FRC = 6'h28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, dbg_attached = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic irq, rst_req;

    int total = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    wdog_keyed #(.TICK_DIV(TDIV), .CNT_W(15), .RST_CYC(RCYC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_attached(dbg_attached), .irq(irq), .rst_req(rst_req)
    );

    task automatic pin(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each scoreboard read as the design answers it
    always @(negedge clk) begin
        #2;
        if (bus_rd && exp_q.size() > 0) pin(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [5:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_exp(A_LOCKB, 16'hDABE, "R1 lockb");
        rd_exp(A_FLAG, 16'h0000, "R1 flag");
        rd_exp(A_LEVEL, 16'h0000, "R1 level");
        rd_exp(A_PERIOD, 16'h7FFF, "R1 period");
        rd_exp(A_EVT, 16'h0000, "R1 evt");
        pin("R1 rst_req", {15'd0, rst_req}, 16'd0);
        pin("R1 irq", {15'd0, irq}, 16'd0);

        // R3 period width
        wr(A_PERIOD, 16'hFFFF);
        rd_exp(A_PERIOD, 16'h7FFF, "R3 all ones");
        wr(A_PERIOD, 16'h8003);
        rd_exp(A_PERIOD, 16'h0003, "R3 top bit dropped");

        // R2 feed ignored while OFF; R4 rearm key
        wr(A_KICK, 16'hFEED);
        rd_exp(A_LEVEL, 16'h0000, "R2 feed in off");
        wr(A_REARM, 16'h1234);
        rd_exp(A_LOCKB, 16'hDABE, "R4 wrong rearm key");
        wr(A_REARM, 16'hACED);
        rd_exp(A_LOCKB, 16'h0000, "R4 rearmed");
        repeat (12) @(negedge clk);
        rd_exp(A_LEVEL, 16'h0000, "R4 no count in armed");
        wr(A_KICK, 16'hBEEF);
        rd_exp(A_LEVEL, 16'h0000, "R2 wrong feed key");
        wr(A_MSK, 16'h0001);

        // countdown from 3: feed edge E0, steps at E4, E8, E12
        wr(A_KICK, 16'hFEED);                    // returns at N0
        rd_exp(A_LEVEL, 16'h0003, "R6 loaded");  // samples after E1
        repeat (5) @(negedge clk);               // N7
        pin("R10 irq before warn", {15'd0, irq}, 16'd0);
        @(negedge clk);                          // N8
        pin("R10 irq at warn", {15'd0, irq}, 16'd1);
        rd_exp(A_EVT, 16'h0001, "R10 evt set");  // N9
        wr(A_EVT, 16'h0001);                     // clear at E12, return N12
        pin("R10 ack", {15'd0, irq}, 16'd0);
        pin("R7 no pulse yet", {15'd0, rst_req}, 16'd0);
        for (int i = 0; i < RCYC; i++) begin
            @(negedge clk);
            pin("R7 pulse high", {15'd0, rst_req}, 16'd1);
        end
        @(negedge clk);
        pin("R7 pulse ended", {15'd0, rst_req}, 16'd0);

        // R8 status
        rd_exp(A_FLAG, 16'hCFE8, "R8 latched");
        wr(A_FLAG, 16'h1234);
        rd_exp(A_FLAG, 16'hCFE8, "R8 wrong clear key");
        rd_exp(A_LEVEL, 16'h0000, "R7 halted");
        repeat (10) @(negedge clk);
        rd_exp(A_LEVEL, 16'h0000, "R7 still halted");
        wr(A_FLAG, 16'hE8B4);
        rd_exp(A_FLAG, 16'h0000, "R8 cleared");

        // R6 / R9 step timing with busy flag
        wr(A_PERIOD, 16'd100);
        wr(A_KICK, 16'hFEED);
        for (int i = 1; i <= 8; i++) begin
            peek(A_LEVEL, v);
            pin("R9 busy", {15'd0, v[15]}, {15'd0, (i % 4) == 3});
            pin("R6 count", {1'b0, v[14:0]}, 16'(100 - i / 4));
        end
        bus_rd = 1'b0;

        // R5 disable sequence
        wr(A_LOCKA, 16'h2BAD);
        wr(A_MSK, 16'h0001);
        wr(A_LOCKB, 16'hCAFE);
        rd_exp(A_LOCKB, 16'h0000, "R5 interrupted");
        wr(A_LOCKA, 16'h2BAD);
        wr(A_LOCKB, 16'h1234);
        rd_exp(A_LOCKB, 16'h0000, "R5 wrong key");
        wr(A_LOCKA, 16'h2BAD);
        wr(A_LOCKB, 16'hCAFE);
        rd_exp(A_LOCKB, 16'hDABE, "R5 disabled");

        // R12 debug freeze
        dbg_attached = 1'b1;
        rd_exp(A_DBG, 16'h0002, "R12 attached flag");
        wr(A_REARM, 16'hACED);
        wr(A_KICK, 16'hFEED);
        repeat (20) @(negedge clk);
        rd_exp(A_LEVEL, 16'd100, "R12 frozen");
        wr(A_DBG, 16'h0001);
        rd_exp(A_DBG, 16'h0003, "R12 run enable");
        repeat (40) @(negedge clk);
        peek(A_LEVEL, v);
        bus_rd = 1'b0;
        pin("R12 runs when allowed", {15'd0, v[14:0] < 15'd100 && v[14:0] > 15'd85}, 16'd1);
        dbg_attached = 1'b0;

        // R11 force, R10 mask
        wr(A_MSK, 16'h0000);
        wr(A_FRC, 16'h0001);
        pin("R10 masked", {15'd0, irq}, 16'd0);
        rd_exp(A_EVT, 16'h0001, "R11 forced");
        wr(A_MSK, 16'h0001);
        pin("R11 irq forced", {15'd0, irq}, 16'd1);
        wr(A_FRC, 16'h0000);
        wr(A_EVT, 16'h0001);
        pin("R10 cleared", {15'd0, irq}, 16'd0);
        rd_exp(A_EVT, 16'h0000, "R11 released");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule